// File: doc/BRIEF.md
# SD Command-Line CRC7 Framer

This block follows one serial frame at a time on an SD/SDIO command line and keeps the 7-bit CRC for it. Bits arrive one per clock on a valid/ready stream. A frame-start pulse opens each frame, and a frame-type select, sampled on that pulse, chooses between a 48-bit command/response and a 136-bit long response. The block counts the bits it accepts, and it decides from the frame type which bit positions feed the CRC register and which pass through without entering it.

When the covered bits have all arrived, the finished CRC sits on `crc_out`, so a transmitter can shift it onto the line. On receive, the seven bits that follow the covered bits are compared with that value. A one-cycle done pulse then reports the result together with an error flag. The last bit of the frame only advances the count. A new frame-start pulse abandons any frame in progress.

The stream input never applies back-pressure: `bit_ready` is always high, and a bit is taken on every cycle where `bit_valid` is high. Bits carry no meaning outside an open frame and are dropped there.

Top module: `cmdline_crc7_framer`

## Requirements
- R1: The CRC uses generator x^7 + x^3 + 1 (feedback mask 7'h09). The register is cleared on each frame-start pulse, and bits enter MSB first: feedback = crc[6] xor bit, and the register shifts left.
- R2: With `long_sel`=0 at the start pulse, frame bit positions 0 to 39 (40 bits, starting with the start bit at position 0) enter the CRC, and the frame is 48 bits long.
- R3: With `long_sel`=1 at the start pulse, the 8 header bits at positions 0 to 7 are skipped, positions 8 to 127 (120 bits) enter the CRC, and the frame is 136 bits long.
- R4: The bit count and the CRC advance only on cycles with `bit_valid` high. Idle cycles inside a frame leave the result unchanged.
- R5: The 7 bits after the covered bits are compared with `crc_out`, MSB first. `crc_done` goes high for exactly one cycle, in the cycle after the seventh of these bits is accepted. `crc_error` goes high at the same edge if any bit differed, and it holds until the next frame-start pulse.
- R6: The final bit of a frame, any bit after the frame length, and any bit before the first frame-start pulse all leave `crc_out`, `crc_done` and `crc_error` untouched.
- R7: A frame-start pulse inside a frame abandons it without a done pulse. A valid bit on the pulse cycle is bit 0 of the new frame.
- R8: `crc_out` keeps the finished CRC until the next frame-start pulse, which clears it to 0. Reset clears `crc_out`, `crc_done` and `crc_error`.
- R9: `bit_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_start | input | 1 | Opens a new frame; the valid bit in the same cycle is bit 0 |
| long_sel | input | 1 | Frame type, sampled with `frm_start`: 0 = 48-bit, 1 = 136-bit |
| bit_valid | input | 1 | Stream valid: `bit_in` carries a line bit |
| bit_ready | output | 1 | Stream ready, always high |
| bit_in | input | 1 | Serial line bit |
| crc_out | output | 7 | Running CRC, final once the covered bits end |
| crc_done | output | 1 | One-cycle pulse after the received CRC field is complete |
| crc_error | output | 1 | Received CRC field differed; valid with `crc_done` |

## Verification
The assertions assume that `frm_start` is a single-cycle event that is never held over several cycles, and that `long_sel` is stable whenever it is sampled. They do not assume that frames are complete or well formed. The bench drives every input at the falling edge and raises `frm_start` for one cycle only. It also sends truncated frames, stray bits outside frames and starts in mid-frame, so the abort and ignore paths are exercised on legal input timing.

// File: rtl/crc7_frm_pkg.sv
package crc7_frm_pkg;
  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    PH_SKIP  = 2'd0,
    PH_COVER = 2'd1,
    PH_CHECK = 2'd2,
    PH_TAIL  = 2'd3
  } phase_e;

  function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] cur,
                                                 input logic bit_v);
    logic fb;
    fb = cur[CRC_W-1] ^ bit_v;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/crc7_frm_seq.sv
module crc7_frm_seq
  import crc7_frm_pkg::*;
#(
  parameter int SHORT_LEN  = 48,
  parameter int LONG_LEN   = 136,
  parameter int SHORT_SKIP = 0,
  parameter int LONG_SKIP  = 8,
  parameter int CNT_W      = $clog2(LONG_LEN + 1),
  parameter int IDX_W      = $clog2(CRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             long_sel,
  input  logic             bit_valid,
  output logic             take,
  output phase_e           phase,
  output logic [IDX_W-1:0] chk_idx,
  output logic             last_chk
);
  localparam int SHORT_COV = SHORT_LEN - SHORT_SKIP - CRC_W - 1;
  localparam int LONG_COV  = LONG_LEN - LONG_SKIP - CRC_W - 1;
  localparam logic [CNT_W-1:0] S_CE = CNT_W'(SHORT_SKIP + SHORT_COV);
  localparam logic [CNT_W-1:0] L_CE = CNT_W'(LONG_SKIP + LONG_COV);

  logic [CNT_W-1:0] cnt_q, cur_cnt, skip_n, cov_end, chk_end, len_n, nxt_cnt;
  logic             act_q, long_q, cur_long, cur_act;

  always_comb begin
    cur_long = frm_start ? long_sel : long_q;
    cur_cnt  = frm_start ? '0 : cnt_q;
    cur_act  = frm_start | act_q;
    take     = bit_valid & cur_act;
    skip_n   = cur_long ? CNT_W'(LONG_SKIP) : CNT_W'(SHORT_SKIP);
    cov_end  = cur_long ? L_CE : S_CE;
    chk_end  = cov_end + CNT_W'(CRC_W);
    len_n    = cur_long ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    nxt_cnt  = cur_cnt + 1'b1;
    if (cur_cnt < skip_n)       phase = PH_SKIP;
    else if (cur_cnt < cov_end) phase = PH_COVER;
    else if (cur_cnt < chk_end) phase = PH_CHECK;
    else                        phase = PH_TAIL;
    chk_idx  = IDX_W'(cur_cnt - cov_end);
    last_chk = take && (phase == PH_CHECK) && (nxt_cnt == chk_end);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      long_q <= 1'b0;
    end else begin
      long_q <= cur_long;
      if (take) begin
        cnt_q <= nxt_cnt;
        act_q <= (nxt_cnt < len_n);
      end else if (frm_start) begin
        cnt_q <= '0;
        act_q <= 1'b1;
      end
    end
  end

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LONG_LEN));
  a_r6_idle_after_len: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nxt_cnt == len_n) |=> !act_q);
endmodule

// File: rtl/crc7_frm_lfsr.sv
module crc7_frm_lfsr
  import crc7_frm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_q
);
  logic [CRC_W-1:0] base;

  always_comb base = clr ? '0 : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= '0;
    else if (en) crc_q <= crc7_next(base, bit_in);
    else         crc_q <= base;
  end
endmodule

// File: rtl/crc7_frm_cmp.sv
module crc7_frm_cmp
  import crc7_frm_pkg::*;
#(
  parameter int IDX_W = $clog2(CRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             chk_en,
  input  logic             last_chk,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             bit_in,
  input  logic [CRC_W-1:0] crc_q,
  output logic             done,
  output logic             err
);
  logic mism_q, mism_n, ref_bit;

  always_comb begin
    ref_bit = crc_q[IDX_W'(CRC_W - 1) - chk_idx];
    mism_n  = mism_q | (bit_in ^ ref_bit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mism_q <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        mism_q <= 1'b0;
        err    <= 1'b0;
      end else if (chk_en) begin
        if (last_chk) begin
          done   <= 1'b1;
          err    <= mism_n;
          mism_q <= 1'b0;
        end else begin
          mism_q <= mism_n;
        end
      end
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  a_r7_start_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done);
endmodule

// File: rtl/cmdline_crc7_framer.sv
module cmdline_crc7_framer
  import crc7_frm_pkg::*;
#(
  parameter int SHORT_LEN  = 48,
  parameter int LONG_LEN   = 136,
  parameter int SHORT_SKIP = 0,
  parameter int LONG_SKIP  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             long_sel,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_out,
  output logic             crc_done,
  output logic             crc_error
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);
  localparam int IDX_W = $clog2(CRC_W);

  logic             take, last_chk, cov_en, chk_en;
  logic [IDX_W-1:0] chk_idx;
  phase_e           phase;

  assign bit_ready = 1'b1;

  crc7_frm_seq #(
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN),
    .SHORT_SKIP(SHORT_SKIP), .LONG_SKIP(LONG_SKIP),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .long_sel(long_sel),
    .bit_valid(bit_valid), .take(take), .phase(phase),
    .chk_idx(chk_idx), .last_chk(last_chk)
  );

  assign cov_en = take && (phase == PH_COVER);
  assign chk_en = take && (phase == PH_CHECK);

  crc7_frm_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(frm_start), .en(cov_en),
    .bit_in(bit_in), .crc_q(crc_out)
  );

  crc7_frm_cmp #(.IDX_W(IDX_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clr(frm_start), .chk_en(chk_en),
    .last_chk(last_chk), .chk_idx(chk_idx), .bit_in(bit_in),
    .crc_q(crc_out), .done(crc_done), .err(crc_error)
  );

  a_r8_crc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_start && !cov_en) |=> $stable(crc_out));
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !cov_en) |=> (crc_out == '0));
  a_r5_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_start && !chk_en) |=> $stable(crc_error));
endmodule

// File: tb/test_cmdline_crc7_framer.sv
`timescale 1ns/1ps
module test_cmdline_crc7_framer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       frm_start = 1'b0, long_sel = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic       bit_ready, crc_done, crc_error;
  logic [6:0] crc_out;

  int n_chk = 0, n_fail = 0, done_seen = 0;
  logic fb [0:135];
  logic [6:0] exp_crc;

  // entry: {long, gap, flip[6:0], seed[22:0]}
  localparam logic [31:0] VEC [0:7] = '{
    {1'b0, 1'b0, 7'h00, 23'd1234}, {1'b1, 1'b0, 7'h00, 23'd777},
    {1'b0, 1'b1, 7'h00, 23'd4242}, {1'b1, 1'b1, 7'h00, 23'd99},
    {1'b0, 1'b0, 7'h40, 23'd5},    {1'b1, 1'b0, 7'h01, 23'd31},
    {1'b0, 1'b1, 7'h12, 23'd600},  {1'b1, 1'b1, 7'h7F, 23'd8191}
  };

  cmdline_crc7_framer i_cmdline_crc7_framer (
    .clk(clk), .rst_n(rst_n), .frm_start(frm_start), .long_sel(long_sel),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_in(bit_in),
    .crc_out(crc_out), .crc_done(crc_done), .crc_error(crc_error)
  );

  always #2 clk = ~clk;
  always @(negedge clk) if (crc_done) done_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] ref_step(input logic [6:0] c, input logic b);
    logic f;
    f = c[6] ^ b;
    ref_step = {c[5:0], 1'b0};
    if (f) ref_step = ref_step ^ 7'b0001001;
  endfunction

  // Random frame; CRC field = correct CRC xor flip
  task automatic build(input bit lng, input logic [6:0] flip, input int unsigned seed);
    int unsigned s = seed;
    int sk = lng ? 8 : 0;
    int cv = lng ? 120 : 40;
    logic [6:0] c = '0;
    for (int i = 0; i < 136; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      fb[i] = s[16];
    end
    for (int i = sk; i < sk + cv; i++) c = ref_step(c, fb[i]);
    exp_crc = c;
    for (int k = 0; k < 7; k++) fb[sk + cv + k] = c[6-k] ^ flip[6-k];
  endtask

  // Sends bits 0..stop-1; checks done timing at the last CRC-field bit
  task automatic send(input bit lng, input bit gap, input int stop, input bit exp_err);
    int last = lng ? 134 : 46;
    for (int i = 0; i < stop; i++) begin
      @(negedge clk);
      frm_start = (i == 0); long_sel = lng; bit_valid = 1'b1; bit_in = fb[i];
      @(posedge clk); #1;
      if (i == last) begin
        chk(crc_done == 1'b1, "R5 done after last CRC bit", crc_done, 1);
        chk(crc_error == exp_err, "R5 error flag", crc_error, exp_err);
      end
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        frm_start = 1'b0; bit_valid = 1'b0; bit_in = ~bit_in;
      end
    end
    @(negedge clk);
    frm_start = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frm_start = 1'b0; bit_valid = 1'b0;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R8 / R9 reset state
    chk(crc_out == 7'h00, "R8 reset crc_out", crc_out, 0);
    chk(crc_done == 1'b0 && crc_error == 1'b0, "R8 reset flags", {crc_done, crc_error}, 0);
    chk(bit_ready == 1'b1, "R9 ready", bit_ready, 1);

    // R6: bits before any frame start ignored
    done_seen = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = i[0] ^ i[2];
    end
    idle(2);
    chk(done_seen == 0 && crc_out == 7'h00, "R6 stray bits ignored", crc_out, 0);

    // R1 R2 R3 R4 R5: vector table
    for (int v = 0; v < 8; v++) begin
      logic lng, gp;
      logic [6:0] fl;
      lng = VEC[v][31]; gp = VEC[v][30]; fl = VEC[v][29:23];
      build(lng, fl, {9'd0, VEC[v][22:0]});
      done_seen = 0;
      send(lng, gp, lng ? 136 : 48, fl != 7'h00);
      idle(3);
      chk(crc_out == exp_crc, lng ? "R3 R1 long CRC" : "R2 R1 short CRC", crc_out, exp_crc);
      chk(done_seen == 1, "R5 single done pulse", done_seen, 1);
      chk(bit_ready == 1'b1, "R9 ready in frame", bit_ready, 1);
    end

    // R5: error held; R6 bits after frame length ignored
    build(1'b0, 7'h08, 32'd321);
    done_seen = 0;
    send(1'b0, 1'b0, 48, 1'b1);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); bit_valid = 1'b1; bit_in = ~bit_in;
    end
    idle(4);
    chk(crc_error == 1'b1, "R5 error held", crc_error, 1);
    chk(crc_out == exp_crc && done_seen == 1, "R6 trailing bits ignored", crc_out, exp_crc);

    // R6: end bit value ignored
    build(1'b1, 7'h00, 32'd55);
    fb[135] = ~fb[135];
    done_seen = 0;
    send(1'b1, 1'b0, 136, 1'b0);
    idle(2);
    chk(crc_error == 1'b0 && crc_out == exp_crc, "R6 end bit ignored", crc_error, 0);

    // R8: start pulse without a bit clears crc_out and error
    build(1'b0, 7'h01, 32'd77);
    send(1'b0, 1'b0, 48, 1'b1);
    @(negedge clk); frm_start = 1'b1; bit_valid = 1'b0;
    @(negedge clk); frm_start = 1'b0;
    chk(crc_out == 7'h00, "R8 start clears crc", crc_out, 0);
    chk(crc_error == 1'b0, "R8 start clears error", crc_error, 0);

    // R7: abort mid-frame, then full frame
    build(1'b1, 7'h00, 32'd901);
    done_seen = 0;
    send(1'b1, 1'b0, 70, 1'b0);
    build(1'b0, 7'h00, 32'd902);
    send(1'b0, 1'b0, 48, 1'b0);
    idle(2);
    chk(done_seen == 1 && crc_out == exp_crc, "R7 abort then frame", crc_out, exp_crc);

    // R7: abort exactly on the last CRC-field bit
    build(1'b0, 7'h00, 32'd4711);
    done_seen = 0;
    send(1'b0, 1'b0, 46, 1'b0);
    build(1'b0, 7'h00, 32'd4712);
    @(negedge clk); frm_start = 1'b1; long_sel = 1'b0; bit_valid = 1'b1; bit_in = fb[0];
    @(negedge clk); frm_start = 1'b0; bit_valid = 1'b0;
    idle(3);
    chk(done_seen == 0, "R7 no done on abort", done_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule